// File: doc/BRIEF.md
# Queued Invalidation Command Engine

This block drains a circular queue of 128-bit invalidation commands kept in memory. Software fills slots, then moves the tail index. The engine fetches the slot under the head index and sends each invalidation to the cache it targets as a one-cycle request pulse. It then moves the head on without waiting for the cache to respond. Each cache port keeps a count of requests still awaiting acknowledgement, so several invalidations can be in flight at once.

A wait command is the synchronisation point. The engine stalls on it until every earlier invalidation on every port has been acknowledged. It then signals completion in one of two ways, chosen by a bit in the command: a one-cycle interrupt pulse, or a 32-bit status write to an address given in the command.

A command of unknown type halts the engine and sets an error flag. The head is left on the faulty slot, so software can repair it and resume.

Top module: `qinv_engine`

## Requirements
- R1: After reset the queue base, head, tail, enable and error flag are all zero. No memory access, invalidation request or interrupt is issued.
- R2: While the head equals the tail, or the enable bit is clear, the engine makes no memory access.
- R3: A command is fetched by a read at byte address base + 16 × head, which returns 128 bits. The register map is: register 0 is the base address, 1 is the tail, 2 is the head (writable only while disabled), and 3 is control/status. In register 3, bit 0 is enable, bit 1 reads as the error flag and clears it when written as 1, and bit 2 reads as busy.
- R4: A command whose bits [3:0] equal 1 gives a one-cycle pulse on inv_req bit 0 (context cache). inv_info carries command bits [127:64]. The head then advances by one.
- R5: Type 2 pulses inv_req bits 1 and 2 (page-directory cache and translation cache) together in the same cycle.
- R6: Type 4 pulses inv_req bit 3 (interrupt-entry cache).
- R7: Invalidations are issued without waiting for acknowledgement, up to MAX_OUT outstanding per port. A port at that limit stalls the next request that targets it.
- R8: A wait command (type 5) does not complete, and the head does not pass it, until every earlier request on all four ports has been acknowledged.
- R9: A wait command with bit 4 set completes with a single-cycle irq pulse and no memory write.
- R10: A wait command with bit 4 clear completes by writing command bits [63:32] to address command bits [64+AW-1:64]. The head advances once that write is acknowledged.
- R11: Any other type sets the error flag, stops the engine and leaves the head on the bad command. Clearing the flag makes the engine fetch that same slot again.
- R12: The head index wraps from DEPTH−1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory access request, held until mem_ack |
| mem_we | output | 1 | 1 = status write, 0 = command fetch |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 32 | Status value to write |
| mem_rdata | input | 128 | Fetched command, valid with mem_ack |
| mem_ack | input | 1 | Access done |
| inv_req | output | 4 | Invalidate pulses: context, page-directory, translation, interrupt-entry |
| inv_info | output | 64 | Scope field of the current command |
| inv_ack | input | 4 | One pulse per completed invalidation, per port |
| irq | output | 1 | Wait-completion interrupt pulse |

## Verification
The embedded assertions check several properties on every cycle. They cover the per-port outstanding limit and single-step head movement. They also cover the freezing of the head while the error flag is set and the single-cycle interrupt. Finally, they check that no status write happens while invalidations are still unacknowledged. The bench scenarios cover what only a stimulus sequence can show. These include the fetch address, the routing of each type to its ports and a batch held back by withheld acknowledgements. They also include the value and address of the status write, recovery from a bad command and the wrap of the head index.

// File: rtl/qinv_engine.sv
module qinv_engine #(
  parameter int AW      = 32,
  parameter int DEPTH   = 8,
  parameter int MAX_OUT = 4,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(MAX_OUT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [127:0]  mem_rdata,
  input  logic          mem_ack,
  output logic [3:0]    inv_req,
  output logic [63:0]   inv_info,
  input  logic [3:0]    inv_ack,
  output logic          irq
);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_EXEC, S_DRAIN, S_WRITE} st_t;

  st_t           st;
  logic [AW-1:0] base_q;
  logic [IW-1:0] head_q, tail_q;
  logic          en_q, err_q;
  logic [127:0]  desc_q;
  logic [CW-1:0] cnt_q [4];
  logic [3:0]    tgt, sat;
  logic          issue, drained, bad, head_inc;

  wire [3:0] dtype = desc_q[3:0];
  wire       irq_mode = desc_q[4];

  always_comb begin
    case (dtype)
      4'd1:    tgt = 4'b0001;
      4'd2:    tgt = 4'b0110;
      4'd4:    tgt = 4'b1000;
      default: tgt = 4'b0000;
    endcase
  end

  assign bad     = (tgt == 4'b0000) && (dtype != 4'd5);
  assign issue   = (st == S_EXEC) && (tgt != 4'b0000) && ((tgt & sat) == 4'b0000);
  assign inv_req = issue ? tgt : 4'b0000;
  assign inv_info = desc_q[127:64];

  genvar g;
  generate
    for (g = 0; g < 4; g++) begin : g_port
      assign sat[g] = (cnt_q[g] == CW'(MAX_OUT));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q[g] <= '0;
        else if (inv_req[g] && !(inv_ack[g] && cnt_q[g] != '0)) cnt_q[g] <= cnt_q[g] + 1'b1;
        else if (!inv_req[g] && inv_ack[g] && cnt_q[g] != '0) cnt_q[g] <= cnt_q[g] - 1'b1;
      end
      a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q[g] == CW'(MAX_OUT)) |-> !inv_req[g]);
    end
  endgenerate

  assign drained  = (cnt_q[0] == '0) && (cnt_q[1] == '0) && (cnt_q[2] == '0) && (cnt_q[3] == '0);
  assign irq      = (st == S_DRAIN) && drained && irq_mode;
  assign head_inc = issue || irq || ((st == S_WRITE) && mem_ack);

  assign mem_req   = (st == S_FETCH) || (st == S_WRITE);
  assign mem_we    = (st == S_WRITE);
  assign mem_addr  = (st == S_WRITE) ? desc_q[64 +: AW] : base_q + (AW'(head_q) << 4);
  assign mem_wdata = desc_q[63:32];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      desc_q <= '0;
      err_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE:  if (en_q && !err_q && head_q != tail_q) st <= S_FETCH;
        S_FETCH: if (mem_ack) begin desc_q <= mem_rdata; st <= S_EXEC; end
        S_EXEC: begin
          if (bad) begin err_q <= 1'b1; st <= S_IDLE; end
          else if (dtype == 4'd5) st <= S_DRAIN;
          else if (issue) st <= S_IDLE;
        end
        S_DRAIN: if (drained) st <= irq_mode ? S_IDLE : S_WRITE;
        S_WRITE: if (mem_ack) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
      if (reg_wr && reg_addr == 2'd3 && reg_wdata[1]) err_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      tail_q <= '0;
      head_q <= '0;
      en_q   <= 1'b0;
    end else begin
      if (head_inc) head_q <= head_q + 1'b1;
      if (reg_wr) begin
        case (reg_addr)
          2'd0: base_q <= AW'(reg_wdata);
          2'd1: tail_q <= reg_wdata[IW-1:0];
          2'd2: if (!en_q && st == S_IDLE) head_q <= reg_wdata[IW-1:0];
          default: en_q <= reg_wdata[0];
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = 32'(base_q);
      2'd1:    reg_rdata = 32'(tail_q);
      2'd2:    reg_rdata = 32'(head_q);
      default: reg_rdata = {29'd0, st != S_IDLE, err_q, en_q};
    endcase
  end

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && (head_q == tail_q || !en_q)) |=> (!mem_req || $past(head_q != tail_q && en_q)));
  a_r4_head_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(head_q) |-> (head_q == $past(head_q) + 1'b1) || $past(reg_wr && reg_addr == 2'd2));
  a_r8_write_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (cnt_q[0] == '0 && cnt_q[1] == '0 && cnt_q[2] == '0 && cnt_q[3] == '0));
  a_r9_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq);
  a_r10_write_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !desc_q[4] && desc_q[3:0] == 4'd5);
  a_r11_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !(reg_wr && reg_addr == 2'd2)) |=> $stable(head_q));

endmodule

// File: tb/sim_qinv_engine.sv
module sim_qinv_engine;
  localparam int AW = 32, DEPTH = 8;
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic mem_req, mem_we, mem_ack = 0, irq;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [127:0] mem_rdata = 0;
  logic [3:0] inv_req, inv_ack = 0;
  logic [63:0] inv_info;

  qinv_engine #(.AW(AW), .DEPTH(DEPTH), .MAX_OUT(4)) u0 (.*);

  always #10 clk = ~clk;

  int errors = 0, checks = 0;
  logic [127:0] dmem [DEPTH];
  int rd_cnt = 0, wr_cnt = 0, irq_cnt = 0;
  logic [31:0] last_rd_addr = 0, wr_addr = 0, wr_data = 0;
  int iss [4], pend [4];
  logic [63:0] last_info = 0;
  logic auto_ack = 1;
  logic done = 0;
  int tail = 0;

  initial for (int i = 0; i < 4; i++) begin iss[i] = 0; pend[i] = 0; end

  always @(posedge clk) begin
    mem_ack <= mem_req && !mem_ack;
    if (mem_req && !mem_ack) begin
      if (!mem_we) begin
        rd_cnt <= rd_cnt + 1;
        last_rd_addr <= mem_addr;
        mem_rdata <= dmem[((mem_addr - BASE) >> 4) % DEPTH];
      end else begin
        wr_cnt <= wr_cnt + 1;
        wr_addr <= mem_addr;
        wr_data <= mem_wdata;
      end
    end
    if (irq) irq_cnt <= irq_cnt + 1;
    if (inv_req != 0) last_info <= inv_info;
    for (int i = 0; i < 4; i++) begin
      int np;
      np = pend[i] + int'(inv_req[i]) - int'(inv_ack[i]);
      pend[i] <= np;
      iss[i] <= iss[i] + int'(inv_req[i]);
      inv_ack[i] <= auto_ack && np > 0;
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wreg(logic [1:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rreg(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  function automatic logic [127:0] mk(logic [3:0] t, logic mode, logic [31:0] data, logic [63:0] hi);
    return {hi, data, 27'd0, mode, t};
  endfunction

  task automatic post(logic [127:0] d);
    dmem[tail % DEPTH] = d;
    tail++;
  endtask

  task automatic kick(); wreg(2'd1, 32'(tail % DEPTH)); endtask

  task automatic settle(int n); repeat (n) @(negedge clk); endtask

  task automatic t_reset();
    logic [31:0] v;
    rreg(2'd2, v); check("R1 head", v, 0);
    rreg(2'd1, v); check("R1 tail", v, 0);
    rreg(2'd3, v); check("R1 status", v, 0);
    check("R1 no mem req", mem_req, 0);
    check("R1 no inv", inv_req, 0);
  endtask

  task automatic t_idle();
    wreg(2'd0, BASE);
    wreg(2'd3, 32'h1);
    settle(20);
    check("R2 no fetch when head==tail", rd_cnt, 0);
  endtask

  task automatic t_ctx();
    logic [31:0] v;
    post(mk(4'd1, 0, 0, 64'hC0FF_EE00_1111_2222));
    kick(); settle(15);
    check("R3 fetch addr", last_rd_addr, BASE);
    check("R4 ctx pulses", iss[0], 1);
    check("R4 info", last_info, 64'hC0FF_EE00_1111_2222);
    rreg(2'd2, v); check("R4 head step", v, 1);
  endtask

  task automatic t_trans();
    post(mk(4'd2, 0, 0, 64'h55));
    kick(); settle(15);
    check("R3 fetch addr slot1", last_rd_addr, BASE + 32'h10);
    check("R5 pde port", iss[1], 1);
    check("R5 tlb port", iss[2], 1);
    check("R5 ctx untouched", iss[0], 1);
  endtask

  task automatic t_intr();
    post(mk(4'd4, 0, 0, 64'h77));
    kick(); settle(15);
    check("R6 intr port", iss[3], 1);
    check("R6 tlb untouched", iss[2], 1);
  endtask

  task automatic t_batch_wait();
    logic [31:0] v;
    auto_ack = 0;
    post(mk(4'd1, 0, 0, 64'h1));
    post(mk(4'd2, 0, 0, 64'h2));
    post(mk(4'd5, 1, 0, 64'h0));
    kick(); settle(40);
    check("R7 ctx issued unacked", iss[0], 2);
    check("R7 tlb issued unacked", iss[2], 2);
    check("R8 no irq before acks", irq_cnt, 0);
    rreg(2'd2, v); check("R8 head held on wait", v, 5);
    auto_ack = 1; settle(15);
    check("R9 irq once", irq_cnt, 1);
    check("R9 no mem write", wr_cnt, 0);
    rreg(2'd2, v); check("R8 head past wait", v, 6);
  endtask

  task automatic t_wait_write();
    logic [31:0] v;
    post(mk(4'd5, 0, 32'hDEAD_BEEF, 64'h0000_0000_0000_2040));
    kick(); settle(20);
    check("R10 one write", wr_cnt, 1);
    check("R10 write addr", wr_addr, 32'h2040);
    check("R10 write data", wr_data, 32'hDEAD_BEEF);
    check("R10 no irq", irq_cnt, 1);
    rreg(2'd2, v); check("R10 head step", v, 7);
  endtask

  task automatic t_bad_and_wrap();
    logic [31:0] v;
    post(mk(4'd7, 0, 0, 64'h9));
    kick(); settle(20);
    rreg(2'd3, v); check("R11 error bit", v[1], 1);
    rreg(2'd2, v); check("R11 head on bad", v, 7);
    check("R11 nothing issued", iss[0] + iss[1] + iss[2] + iss[3], 7);
    dmem[7] = mk(4'd1, 0, 0, 64'hAB);
    wreg(2'd3, 32'h3); settle(20);
    rreg(2'd3, v); check("R11 error cleared", v[1], 0);
    check("R11 refetched slot", iss[0], 3);
    check("R11 refetch addr", last_rd_addr, BASE + 32'h70);
    rreg(2'd2, v); check("R12 head wraps", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_idle();
    t_ctx();
    t_trans();
    t_intr();
    t_batch_wait();
    t_wait_write();
    t_bad_and_wrap();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule